// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block takes a 36-bit local address from an outbound transaction and maps it onto a 64-bit PCI-side address. A small bank of programmable windows does the mapping. Each window has three fields: a base, an attribute word and a translation base. Software programs them through a plain word-wide register port. Window 0 is the fallback. It is always enabled and never compared against the address. Windows 1 to 4 are matched against each request, and the lowest-numbered enabled window that matches wins.

For every valid request the block returns three results one cycle later: the translated address, the index of the window that was used, and a flag that is set when the fallback window was used. A window spans 2^s bytes, where s is a log2 size code from 12 (4 KB) to 34 (16 GB). Only the address bits at and above s are compared. The translated address takes its bits at and above s from the window's translation base and keeps the local bits below s.

Top module: `obwin_xlate`

## Requirements
- R1: When no enabled window among 1..4 matches, the result uses window 0: `hit_idx` is 0, `dflt_hit` is 1, and the translation comes from window 0's registers.
- R2: Window 0's base register can be written and read back, but its value never affects which window matches.
- R3: The register word address is `{window, field, 2'b00}`, which gives each window a 0x20-byte stride. The field codes are: 0 = base, 1 = attribute, 2 = translation bits [43:12], 3 = translation bits [63:44] held in data bits [19:0]. Any other field or window reads as 0.
- R4: In the base word, bits [23:20] hold local address bits [35:32] and bits [19:0] hold local address bits [31:12]. Bits [31:24] are not stored and read as zero.
- R5: In the attribute word, bit 31 is the enable and bits [5:0] are the size code s. A window 1..4 takes part in matching only when its enable is 1 and 12 ≤ s ≤ 34. Window 0 always reads enable = 1.
- R6: Window i matches when local address bits [35:s] equal its base bits [35:s]. The base bits below s are ignored.
- R7: When several windows match, the lowest-numbered one is chosen.
- R8: The translated address is the translation base with bits [s-1:0] replaced by the local address bits [s-1:0]. For window 0, an illegal size code is treated as s = 12.
- R9: `out_valid` and the results appear exactly one cycle after `req_valid`. `out_valid` is low in the cycle after a cycle with no request.
- R10: A register write affects requests presented in the following cycle and later, not a request presented in the same cycle as the write.
- R11: After reset, windows 1..4 are disabled, every base and translation field is zero, every size code is 12, and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Request present |
| req_addr | input | 36 | Local address of the request |
| out_valid | output | 1 | Results valid |
| xl_addr | output | 64 | Translated address |
| hit_idx | output | 3 | Index of the window used |
| dflt_hit | output | 1 | Fallback window was used |

## Verification
Register reads are combinational, so the bench checks them in the same low clock phase in which it applies `reg_addr`. Translation results are registered once. Each request is driven at a falling edge and compared at the next falling edge, which is the first point at which that edge's registered result is visible. A write takes one rising edge to land. The bench therefore drives a write and a request in the same cycle and expects the old mapping for that request, and it expects the new mapping for the request in the cycle that follows.

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int NWIN = 5,
  localparam int WSEL = $clog2(NWIN),
  localparam int RAW = WSEL + 5,
  localparam int LAW = 36,
  localparam int PAW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            req_valid,
  input  logic [LAW-1:0]  req_addr,
  output logic            out_valid,
  output logic [PAW-1:0]  xl_addr,
  output logic [WSEL-1:0] hit_idx,
  output logic            dflt_hit
);
  localparam logic [5:0] SZ_MIN = 6'd12;
  localparam logic [5:0] SZ_MAX = 6'd34;

  logic [23:0] base_q [NWIN];
  logic        en_q   [NWIN];
  logic [5:0]  sz_q   [NWIN];
  logic [31:0] tl_q   [NWIN];
  logic [19:0] te_q   [NWIN];

  function automatic logic legal(input logic [5:0] s);
    return (s >= SZ_MIN) && (s <= SZ_MAX);
  endfunction

  wire [WSEL-1:0] r_win = reg_addr[RAW-1:5];
  wire [2:0]      r_fld = reg_addr[4:2];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NWIN; i++) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        en_q[i]   <= 1'b0;
        sz_q[i]   <= SZ_MIN;
        tl_q[i]   <= '0;
        te_q[i]   <= '0;
      end else if (reg_we && r_win == WSEL'(i)) begin
        case (r_fld)
          3'd0: base_q[i] <= reg_wdata[23:0];
          3'd1: begin en_q[i] <= reg_wdata[31]; sz_q[i] <= reg_wdata[5:0]; end
          3'd2: tl_q[i] <= reg_wdata;
          3'd3: te_q[i] <= reg_wdata[19:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (r_win == WSEL'(i)) begin
        case (r_fld)
          3'd0: reg_rdata = {8'h00, base_q[i]};
          3'd1: reg_rdata = {en_q[i] || (i == 0), 25'd0, sz_q[i]};
          3'd2: reg_rdata = tl_q[i];
          3'd3: reg_rdata = {12'h000, te_q[i]};
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  logic [WSEL-1:0] sel;
  logic [5:0]      sel_sz;
  logic [PAW-1:0]  low_m, tbase, xl_d;

  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 1; i--) begin
      if (en_q[i] && legal(sz_q[i]) &&
          (((req_addr ^ {base_q[i], 12'h000}) & ~((LAW'(1) << sz_q[i]) - LAW'(1))) == '0))
        sel = WSEL'(i);
    end
    sel_sz = SZ_MIN;
    tbase  = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (sel == WSEL'(i)) begin
        sel_sz = legal(sz_q[i]) ? sz_q[i] : SZ_MIN;
        tbase  = {te_q[i], tl_q[i], 12'h000};
      end
    end
    low_m = (PAW'(1) << sel_sz) - PAW'(1);
    xl_d  = (tbase & ~low_m) | ({{(PAW-LAW){1'b0}}, req_addr} & low_m);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      xl_addr   <= '0;
      hit_idx   <= '0;
      dflt_hit  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        xl_addr  <= xl_d;
        hit_idx  <= sel;
        dflt_hit <= (sel == '0);
      end
    end
  end
endmodule

module obwin_xlate_chk #(
  parameter int NWIN = 5,
  localparam int WSEL = $clog2(NWIN),
  localparam int RAW = WSEL + 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RAW-1:0]  reg_addr,
  input logic [31:0]     reg_rdata,
  input logic            req_valid,
  input logic [35:0]     req_addr,
  input logic            out_valid,
  input logic [63:0]     xl_addr,
  input logic [WSEL-1:0] hit_idx,
  input logic            dflt_hit
);
  AST_DFLT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && dflt_hit) |-> hit_idx == '0); // R1
  AST_IDX_IN_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> int'(hit_idx) < NWIN); // R7
  AST_RESULT_DUE:    assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> out_valid); // R9
  AST_NO_SPURIOUS:   assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !out_valid); // R9
  AST_PAGE_OFFSET:   assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> xl_addr[11:0] == $past(req_addr[11:0])); // R8
  AST_BASE_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_addr[4:2] == 3'd0 |-> reg_rdata[31:24] == 8'h00); // R4
  AST_DFLT_ENABLED:  assert property (@(posedge clk) disable iff (!rst_n) (reg_addr[4:2] == 3'd1 && reg_addr[RAW-1:5] == '0) |-> reg_rdata[31]); // R5
endmodule

bind obwin_xlate obwin_xlate_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
  .xl_addr(xl_addr), .hit_idx(hit_idx), .dflt_hit(dflt_hit)
);

// File: tb/sim_obwin_xlate.sv
`timescale 1ns/1ps
module sim_obwin_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic out_valid;
  logic [63:0] xl_addr;
  logic [2:0] hit_idx;
  logic dflt_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [23:0] sb_base [5];
  bit          sb_en   [5];
  logic [5:0]  sb_sz   [5];
  logic [31:0] sb_tl   [5];
  logic [19:0] sb_te   [5];

  always #4 clk = ~clk;

  obwin_xlate u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .out_valid(out_valid), .xl_addr(xl_addr),
    .hit_idx(hit_idx), .dflt_hit(dflt_hit)
  );

  function automatic bit ok_sz(input logic [5:0] s);
    return s >= 12 && s <= 34;
  endfunction

  function automatic void model(input logic [35:0] a, output logic [63:0] x, output int ix);
    logic [63:0] t, a64;
    int s;
    ix = 0;
    for (int i = 4; i >= 1; i--)
      if (sb_en[i] && ok_sz(sb_sz[i]) && ((a >> sb_sz[i]) == ({sb_base[i], 12'h000} >> sb_sz[i])))
        ix = i;
    s = ok_sz(sb_sz[ix]) ? int'(sb_sz[ix]) : 12;
    t = {sb_te[ix], sb_tl[ix], 12'h000};
    a64 = {28'h0, a};
    x = ((t >> s) << s) | (a64 - ((a64 >> s) << s));
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {w[2:0], f[2:0], 2'b00}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (f)
      0: sb_base[w] = d[23:0];
      1: begin sb_en[w] = d[31]; sb_sz[w] = d[5:0]; end
      2: sb_tl[w] = d;
      3: sb_te[w] = d[19:0];
      default: ;
    endcase
  endtask

  task automatic rd(input string tag, input int w, input int f, input logic [31:0] exp);
    reg_addr = {w[2:0], f[2:0], 2'b00};
    #1;
    check(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic req(input string tag, input logic [35:0] a);
    logic [63:0] ex; int ix;
    @(negedge clk);
    model(a, ex, ix);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, (ix == 0) ? " R1 addr" : " R8 addr"}, xl_addr, ex);
    check({tag, " R7 R6 idx"}, {61'h0, hit_idx}, 64'(ix));
    check({tag, " R1 flag"}, {63'h0, dflt_hit}, {63'h0, ix == 0});
    check({tag, " R9 valid"}, {63'h0, out_valid}, 64'h1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] pts [6];
    logic [63:0] lf;
    for (int i = 0; i < 5; i++) begin
      sb_base[i] = '0; sb_en[i] = 1'b0; sb_sz[i] = 6'd12; sb_tl[i] = '0; sb_te[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 valid after reset", {63'h0, out_valid}, 64'h0);
    rd("R11 attr w1", 1, 1, 32'h0000_000C);
    rd("R11 base w3", 3, 0, 32'h0);
    rd("R5 attr w0 enabled", 0, 1, 32'h8000_000C);
    req("R11 default after reset", 36'h9_8765_4321);

    wr(1, 0, 32'hFFF1_2345);
    rd("R4 base pad", 1, 0, 32'h00F1_2345);
    rd("R3 unmapped field", 1, 5, 32'h0);
    rd("R3 unmapped window", 6, 0, 32'h0);
    wr(1, 0, 32'h0010_0000);
    wr(1, 2, 32'h1234_5678);
    wr(1, 3, 32'hFFFA_BCDE);
    rd("R3 trans low", 1, 2, 32'h1234_5678);
    rd("R3 trans ext", 1, 3, 32'h000A_BCDE);

    @(negedge clk);
    req_valid = 1'b1; req_addr = 36'h1_0000_1ABC;
    reg_we = 1'b1; reg_addr = {3'd1, 3'd1, 2'b00}; reg_wdata = 32'h8000_0010;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    check("R10 same cycle old map", {61'h0, hit_idx}, 64'h0);
    sb_en[1] = 1'b1; sb_sz[1] = 6'd16;
    req("R10 next cycle new map", 36'h1_0000_1ABC);
    rd("R5 attr w1", 1, 1, 32'h8000_0010);

    wr(2, 0, 32'h0010_0000); wr(2, 1, 32'h8000_0014);
    wr(2, 2, 32'hCAFE_F00D); wr(2, 3, 32'h0001_2345);
    wr(3, 0, 32'h0080_0000); wr(3, 1, 32'h8000_0022);
    wr(3, 2, 32'h0000_0000); wr(3, 3, 32'h000F_FFFF);
    wr(4, 0, 32'h0000_0005); wr(4, 1, 32'h8000_000C);
    wr(4, 2, 32'h7777_7000); wr(4, 3, 32'h0005_5555);
    wr(0, 0, 32'h0000_0006); wr(0, 1, 32'h0000_0014);
    wr(0, 2, 32'h0BAD_0000); wr(0, 3, 32'h0000_0042);
    rd("R2 base w0 readback", 0, 0, 32'h0000_0006);
    rd("R5 w0 enable forced", 0, 1, 32'h8000_0014);
    req("R2 w0 base ignored", 36'h0_0000_6123);

    pts[0] = 36'h1_0000_0000; pts[1] = 36'h1_0001_0000; pts[2] = 36'h8_0000_0000;
    pts[3] = 36'h0_0000_5000; pts[4] = 36'h0_0000_6000; pts[5] = 36'h7_FFFF_F000;
    for (int p = 0; p < 6; p++)
      for (int j = 0; j < 48; j++)
        req("R6 sweep", pts[p] + 36'(j * 1027) - 36'h0_0000_6000 + 36'(j << 11));

    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 400; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
      req("R8 scatter", lf[35:0]);
    end

    wr(4, 1, 32'h8000_0023);
    req("R5 size 35 illegal", 36'h0_0000_5ABC);
    wr(4, 1, 32'h8000_000B);
    req("R5 size 11 illegal", 36'h0_0000_5ABC);
    wr(1, 1, 32'h0000_0010);
    req("R5 enable off, R7 falls to w2", 36'h1_0000_0123);
    wr(0, 1, 32'h0000_003F);
    req("R8 w0 illegal size as 12", 36'h0_0000_0FFF);

    @(negedge clk);
    @(negedge clk);
    check("R9 idle no valid", {63'h0, out_valid}, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule